// File: doc/BRIEF.md
# Floating-point compare into condition-code field

This block compares two IEEE binary floating-point values of one format and reports their relation as a 2-bit condition code. The code is written into one of four condition-code fields of a wide status word. The format defaults to single precision and is set by two parameters: the exponent width and the fraction width. Double and quad need only a change of these two values.

A caller presents both operands, the present status word, a 2-bit field select and a compare-kind select, and then pulses a start strobe for one cycle. One clock later the block returns the updated status word and a 5-bit exception vector, together with a one-cycle done pulse. The compare-kind select picks between a quiet compare and a signalling compare. The signalling compare flags invalid-operation on any unordered result. The quiet compare flags it only when a signalling NaN is present. Only the selected 2-bit field of the status word changes. Every other bit passes through from the status input.

Top module: `fcmp_fcc_unit`

## Requirements
- R1: While rst_n is low at a clock edge, stat_o, exc_o and done_o all become zero.
- R2: done_o is 1 in exactly the cycles that follow a clock edge at which start_i was 1, and 0 otherwise, including when start_i is held for several cycles.
- R3: For ordered operands the code is 0 when op_a_i equals op_b_i, 1 when op_a_i is less and 2 when op_a_i is greater. Ordering is by real value, so negative operands, mixed signs and infinities are ordered correctly.
- R4: Positive zero and negative zero compare equal (code 0), in either operand order.
- R5: An operand is a NaN when its exponent is all ones and its fraction is nonzero. If either operand is a NaN the code is 3 (unordered). An all-ones exponent with a zero fraction is an infinity and is ordered.
- R6: With signal_i = 1, an unordered result sets exc_o bit 4 (invalid-operation).
- R7: With signal_i = 0, exc_o bit 4 is set only when an operand is a signalling NaN, which is a NaN whose fraction MSB is 0. A quiet NaN (fraction MSB 1) gives code 3 with exc_o bit 4 clear.
- R8: fcc_sel_i picks the destination field of stat_o: 0 writes bits 11:10, 1 writes bits 33:32, 2 writes bits 35:34 and 3 writes bits 37:36. All other bits of stat_o equal stat_i as sampled at the start edge.
- R9: exc_o bits 3:0 are always 0, and exc_o bit 4 is 0 for every ordered result.
- R10: stat_o and exc_o keep their values across any edge at which start_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch one compare this cycle |
| signal_i | input | 1 | 1 = signalling compare, 0 = quiet compare |
| fcc_sel_i | input | 2 | Destination condition-code field |
| op_a_i | input | EXP_W+FRAC_W+1 | First operand |
| op_b_i | input | EXP_W+FRAC_W+1 | Second operand |
| stat_i | input | STAT_W | Status word to update |
| stat_o | output | STAT_W | Updated status word |
| exc_o | output | 5 | Exception vector; bit 4 is invalid-operation |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The hardest cases to reach are the operands that sit right at the NaN boundary. An infinity and a NaN differ only in the lowest fraction bit. A signalling NaN and a quiet NaN differ only in the fraction MSB. The stimulus therefore uses hand-picked encodings with an all-ones exponent: zero fraction, fraction 1 and fraction MSB set. Each is used in both operand positions and under both compare kinds. Field isolation is proved with all-ones and all-zero status backgrounds, so a stray write or a missed clear in any neighbouring bit shows at the output.

// File: rtl/fcmp_pkg.sv
// Package fcmp_pkg: result codes, exception layout and condition-code field
// positions shared by the compare unit and its checker.
package fcmp_pkg;
    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    localparam int EXC_W       = 5;
    localparam int EXC_INVALID = 4;
    localparam int FCC_FIELDS  = 4;

    // Low bit of the condition-code field chosen by sel.
    function automatic int fcc_lsb(input logic [1:0] sel);
        return (sel == 2'd0) ? 10 : 30 + 2 * int'(sel);
    endfunction
endpackage

// File: rtl/fcmp_classify.sv
// Module fcmp_classify: splits one operand into sign and magnitude and
// flags NaN, signalling NaN and zero.
// Assumes IEEE binary layout {sign, exponent, fraction}, with the fraction
// MSB acting as the quiet bit.
module fcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int MAG_W = EXP_W + FRAC_W
) (
    input  logic [MAG_W:0]   op,
    output logic             sign,
    output logic [MAG_W-1:0] mag,
    output logic             is_nan,
    output logic             is_snan,
    output logic             is_zero
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    // Field split and classification of the operand.
    always_comb begin
        sign    = op[MAG_W];
        mag     = op[MAG_W-1:0];
        exp_f   = op[MAG_W-1 -: EXP_W];
        frac_f  = op[FRAC_W-1:0];
        is_nan  = (&exp_f) && (|frac_f);
        is_snan = is_nan && !frac_f[FRAC_W-1];
        is_zero = (mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
// Module fcmp_order: turns two classified operands into a relation code.
// Uses sign-magnitude order: mixed signs decide on sign, equal signs
// compare magnitude and invert the result for negatives. Two zeros of any
// sign are equal, and any NaN gives unordered.
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             zero_a,
    input  logic             zero_b,
    input  logic             nan_a,
    input  logic             nan_b,
    output rel_e             rel
);
    logic mag_lt;
    logic mag_eq;

    // Relation decision with priority NaN, zeros, sign, magnitude.
    always_comb begin
        mag_lt = (mag_a < mag_b);
        mag_eq = (mag_a == mag_b);
        if (nan_a || nan_b)
            rel = REL_UN;
        else if (zero_a && zero_b)
            rel = REL_EQ;
        else if (sign_a != sign_b)
            rel = sign_a ? REL_LT : REL_GT;
        else if (mag_eq)
            rel = REL_EQ;
        else if (mag_lt ^ sign_a)
            rel = REL_LT;
        else
            rel = REL_GT;
    end
endmodule

// File: rtl/fcmp_fcc_merge.sv
// Module fcmp_fcc_merge: places a 2-bit code into one of the four
// condition-code fields of the status word and keeps every other bit.
// Assumes STAT_W >= 38 so that the highest field fits.
module fcmp_fcc_merge
    import fcmp_pkg::*;
#(
    parameter int STAT_W = 64
) (
    input  logic [STAT_W-1:0] stat_in,
    input  logic [1:0]        sel,
    input  rel_e              rel,
    output logic [STAT_W-1:0] stat_out
);
    // Copy the word, then overwrite the selected field.
    always_comb begin
        stat_out = stat_in;
        for (int g = 0; g < FCC_FIELDS; g++) begin
            if (sel == 2'(g))
                stat_out[fcc_lsb(2'(g)) +: 2] = rel;
        end
    end
endmodule

// File: rtl/fcmp_fcc_unit.sv
// Module fcmp_fcc_unit: top of the compare. Classifies both operands,
// orders them, decides invalid-operation and registers the merged status
// word and exception vector one cycle after start, with a done pulse.
// Assumes both operands share one format, given by EXP_W and FRAC_W.
module fcmp_fcc_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int STAT_W = 64,
    localparam int MAG_W = EXP_W + FRAC_W,
    localparam int OP_W  = MAG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              signal_i,
    input  logic [1:0]        fcc_sel_i,
    input  logic [OP_W-1:0]   op_a_i,
    input  logic [OP_W-1:0]   op_b_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [STAT_W-1:0] stat_o,
    output logic [EXC_W-1:0]  exc_o,
    output logic              done_o
);
    logic             sign_a, sign_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             nan_a, nan_b, snan_a, snan_b, zero_a, zero_b;
    rel_e             rel;
    logic [STAT_W-1:0] stat_nxt;
    logic [EXC_W-1:0]  exc_nxt;

    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
        .op(op_a_i), .sign(sign_a), .mag(mag_a),
        .is_nan(nan_a), .is_snan(snan_a), .is_zero(zero_a)
    );

    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
        .op(op_b_i), .sign(sign_b), .mag(mag_b),
        .is_nan(nan_b), .is_snan(snan_b), .is_zero(zero_b)
    );

    fcmp_order #(.MAG_W(MAG_W)) u_ord (
        .sign_a(sign_a), .sign_b(sign_b), .mag_a(mag_a), .mag_b(mag_b),
        .zero_a(zero_a), .zero_b(zero_b), .nan_a(nan_a), .nan_b(nan_b),
        .rel(rel)
    );

    fcmp_fcc_merge #(.STAT_W(STAT_W)) u_merge (
        .stat_in(stat_i), .sel(fcc_sel_i), .rel(rel), .stat_out(stat_nxt)
    );

    // Invalid-operation: any unordered signalling compare, or any sNaN.
    always_comb begin
        exc_nxt = '0;
        exc_nxt[EXC_INVALID] = (rel == REL_UN) && (signal_i || snan_a || snan_b);
    end

    // Result registers: capture on start, hold otherwise, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= '0;
            exc_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                stat_o <= stat_nxt;
                exc_o  <= exc_nxt;
            end
        end
    end
endmodule

// File: rtl/fcmp_fcc_chk.sv
// Module fcmp_fcc_chk: protocol and field-isolation properties of
// fcmp_fcc_unit, attached through bind.
module fcmp_fcc_chk
    import fcmp_pkg::*;
#(
    parameter int STAT_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [1:0]        fcc_sel_i,
    input logic [STAT_W-1:0] stat_i,
    input logic [STAT_W-1:0] stat_o,
    input logic [EXC_W-1:0]  exc_o,
    input logic              done_o
);
    logic [1:0]        sel_q;
    logic [STAT_W-1:0] field_mask;
    logic [1:0]        field_val;

    // Remember the field select of the latest start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 2'd0;
        else if (start_i)
            sel_q <= fcc_sel_i;
    end

    // Mask and value of the field written by the latest start.
    always_comb begin
        field_mask = '0;
        field_mask[fcc_lsb(sel_q) +: 2] = 2'b11;
        field_val  = stat_o[fcc_lsb(sel_q) +: 2];
    end

    // R2
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(stat_o) && $stable(exc_o)));

    // R8
    other_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (((stat_o ^ $past(stat_i)) & ~field_mask) == '0));

    // R9
    invalid_only_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exc_o[EXC_INVALID]) |-> (field_val == 2'd3));
endmodule

bind fcmp_fcc_unit fcmp_fcc_chk #(.STAT_W(STAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fcc_sel_i(fcc_sel_i),
    .stat_i(stat_i), .stat_o(stat_o), .exc_o(exc_o), .done_o(done_o)
);

// File: tb/sim_fcmp_fcc_unit.sv
module sim_fcmp_fcc_unit;
    localparam int STAT_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              signal_i = 1'b0;
    logic [1:0]        fcc_sel_i = 2'd0;
    logic [31:0]       op_a_i = '0;
    logic [31:0]       op_b_i = '0;
    logic [STAT_W-1:0] stat_i = '0;
    logic [STAT_W-1:0] stat_o;
    logic [4:0]        exc_o;
    logic              done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fcmp_fcc_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signal_i(signal_i),
        .fcc_sel_i(fcc_sel_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .stat_i(stat_i), .stat_o(stat_o), .exc_o(exc_o), .done_o(done_o)
    );

    function automatic bit ref_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic bit ref_snan(input logic [31:0] v);
        return ref_nan(v) && (v[22] == 1'b0);
    endfunction

    function automatic int ref_rel(input logic [31:0] a, input logic [31:0] b);
        longint ka, kb;
        if (ref_nan(a) || ref_nan(b)) return 3;
        ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
        kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
        if (ka == kb) return 0;
        return (ka < kb) ? 1 : 2;
    endfunction

    function automatic logic [STAT_W-1:0] ref_merge(input logic [STAT_W-1:0] s,
                                                   input int sel, input int code);
        int p;
        logic [STAT_W-1:0] r;
        p = (sel == 0) ? 10 : 30 + 2 * sel;
        r = s;
        r[p]   = code[0];
        r[p+1] = code[1];
        return r;
    endfunction

    // Cycle model
    logic [STAT_W-1:0] m_stat;
    logic [4:0]        m_exc;
    logic              m_done;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat <= '0; m_exc <= '0; m_done <= 1'b0;
        end else begin
            m_done <= start_i;
            if (start_i) begin
                m_stat <= ref_merge(stat_i, int'(fcc_sel_i), ref_rel(op_a_i, op_b_i));
                m_exc  <= ((ref_rel(op_a_i, op_b_i) == 3) &&
                           (signal_i || ref_snan(op_a_i) || ref_snan(op_b_i))) ? 5'h10 : 5'h00;
            end
        end
    end

    // R10 and R2: compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (stat_o !== m_stat || exc_o !== m_exc || done_o !== m_done) begin
                fails++;
                $display("FAIL R10 model: got stat=%h exc=%h done=%b exp stat=%h exc=%h done=%b",
                         stat_o, exc_o, done_o, m_stat, m_exc, m_done);
            end
        end
    end

    task automatic chk(input string tag, input logic [STAT_W-1:0] got,
                       input logic [STAT_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b, input bit sig,
                       input int sel, input logic [STAT_W-1:0] st,
                       input int code, input bit inv, input string tag);
        @(negedge clk);
        op_a_i = a; op_b_i = b; signal_i = sig; fcc_sel_i = 2'(sel);
        stat_i = st; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stat_i = ~st;
        chk({tag, " stat"}, stat_o, ref_merge(st, sel, code));
        chk({tag, " exc"}, {59'd0, exc_o}, {59'd0, inv, 4'b0000});
        chk("R2 done", {63'd0, done_o}, 64'd1);
        @(negedge clk);
        chk("R10 hold", stat_o, ref_merge(st, sel, code));
        chk("R2 done low", {63'd0, done_o}, 64'd0);
    endtask

    localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
    localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
    localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
    localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
    localparam logic [31:0] PMAX = 32'h7F7FFFFF;
    localparam logic [31:0] QNAN = 32'h7FC00000, SNAN = 32'h7F800001;
    localparam logic [STAT_W-1:0] ONES = '1;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 stat", stat_o, '0);
        chk("R1 exc/done", {58'd0, exc_o, done_o}, '0);
        rst_n = 1'b1;

        run(P1, P2, 0, 0, '0, 1, 0, "R3 less");
        run(P2, P1, 0, 0, '0, 2, 0, "R3 greater");
        run(P1, P1, 1, 0, '0, 0, 0, "R3 equal");
        run(N1, N2, 0, 1, '0, 2, 0, "R3 negatives");
        run(N2, P1, 0, 2, '0, 1, 0, "R3 mixed sign");
        run(NINF, N2, 0, 3, '0, 1, 0, "R3 neg inf");
        run(PZ, NZ, 1, 0, '0, 0, 0, "R4 +0 -0");
        run(NZ, PZ, 0, 1, '0, 0, 0, "R4 -0 +0");
        run(PINF, PMAX, 1, 0, '0, 2, 0, "R5 inf ordered");
        run(QNAN, P1, 0, 0, '0, 3, 0, "R7 quiet qNaN");
        run(P1, QNAN, 1, 0, '0, 3, 1, "R6 signalling qNaN");
        run(SNAN, P1, 0, 2, '0, 3, 1, "R7 quiet sNaN a");
        run(P1, SNAN, 0, 3, '0, 3, 1, "R7 quiet sNaN b");
        run(PINF, SNAN, 1, 1, '0, 3, 1, "R5 inf vs NaN");
        run(P1, P2, 0, 0, ONES, 1, 0, "R8 field0");
        run(P1, P2, 0, 1, ONES, 1, 0, "R8 field1");
        run(P2, P1, 0, 2, ONES, 2, 0, "R8 field2");
        run(P1, P1, 0, 3, ONES, 0, 0, "R8 field3");
        run(QNAN, QNAN, 0, 3, 64'h00F0_0000_5A5A_A5A5, 3, 0, "R9 no flag");

        // R2: start held for two cycles, back-to-back results
        @(negedge clk);
        op_a_i = P1; op_b_i = P2; fcc_sel_i = 2'd0; stat_i = '0; signal_i = 0;
        start_i = 1'b1;
        @(negedge clk);
        chk("R2 b2b first", stat_o, ref_merge('0, 0, 1));
        op_a_i = P2; op_b_i = P1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 b2b second", stat_o, ref_merge('0, 0, 2));
        chk("R2 b2b done", {63'd0, done_o}, 64'd1);
        @(negedge clk);
        chk("R2 b2b end", {63'd0, done_o}, 64'd0);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset", {stat_o[57:0], exc_o, done_o}, '0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule